// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of an Ethernet MAC that keeps its buffer descriptors in a small internal memory. Each descriptor holds a 16-bit status word, a 16-bit length and a 32-bit buffer address. Software prepares a ring of descriptors and marks each one it hands over as empty. It programs the index of the first descriptor and enables the engine. It then writes a fixed arming value to a poke register. Received frames arrive as a byte stream with a last-beat marker and per-beat error flags. The engine writes each byte to the buffer of the current descriptor. When the frame ends it writes back the length, the error summary and a last-in-frame flag, and clears the empty bit so that software owns the descriptor again.

The ring has no fixed size. A wrap bit in a descriptor marks the end of the ring, and the descriptor after it is the ring start. When the engine reaches a descriptor that software has not yet emptied, it stops and waits for the next poke. A frame that finds no usable descriptor is dropped whole and counted in a sticky overrun counter. The stored length includes the 4 CRC bytes. Frames longer than the frame limit are flagged, and bytes beyond the buffer size are not stored.

Top module: `rx_bd_ring`

## Requirements
- R1: After reset the control register reads 0 (disabled), the overrun counter reads 0, every descriptor word reads 0 and no buffer write is issued.
- R2: A frame is stored only into the current descriptor, and only when the engine is armed and that descriptor's empty bit (status bit 15) is 1. Byte k of the frame (k counting from 0) is written to buffer address + k, with buf_we high one cycle after the beat.
- R3: At the frame's last beat the descriptor's word 0 becomes {status, length}. The status has bit 15 (empty) cleared, bit 11 (last in frame) set and bit 13 (wrap) kept as before. The length is the number of bytes received, CRC included.
- R4: After a descriptor whose wrap bit 13 is set, the next frame goes to the ring-start descriptor. After any other descriptor, it goes to the next index.
- R5: A host write of exactly 0x01000000 to register offset 2 arms the engine, and any other value does not. When the current descriptor is not empty, the engine disarms and keeps dropping frames, even after software sets the empty bit, until the next valid poke.
- R6: The 5 rx_err bits, ORed over all beats of a frame, land in status bits 4:0. Status bits 5:0 are all 0 for a good frame of legal length.
- R7: A frame longer than FRAME_MAX (1518) bytes sets status bit 5. Bytes past BUF_MAX (1520) are not written, and the stored length is then BUF_MAX.
- R8: A frame that finds no usable descriptor causes no buffer write and leaves the descriptor unchanged. It increments the overrun counter (register offset 3) by 1.
- R9: While disabled (control bit 0 = 0), input frames are ignored: no writes and no count. Reset or disable returns the current descriptor to the ring start (register offset 1).
- R10: host_rdata returns the word addressed by host_addr one cycle later. Addresses with the top bit 0 select descriptor host_addr[HA_W-2:1], word host_addr[0] (0 = {status,length}, 1 = buffer address). Addresses with the top bit 1 select register host_addr[1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | HA_W | Host word address (descriptor or register space) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after address |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Last byte of frame |
| rx_err | input | 5 | Per-beat receive error flags |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_waddr | output | ADDR_W | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |

## Verification
Buffer byte writes are due on the cycle after their beat, so a monitor samples buf_we at each falling edge and compares address and data with a pattern that the bench generates for every frame. The descriptor write-back and the overrun count update on the rising edge of the last beat. Host reads return one cycle after the address is presented, so the bench puts the address out at one falling edge and samples the data at the next. It reads only after the frame has ended and two idle cycles have passed. The dropped, disabled and not-rearmed cases are judged by the write count and by reading back the descriptor and the counter.

// File: rtl/rx_bd_pkg.sv
// Shared constants and types for the receive descriptor ring engine.
// Assumes a 16-bit status word with the bit positions below.
package rx_bd_pkg;
    localparam int ST_EMPTY   = 15;
    localparam int ST_WRAP    = 13;
    localparam int ST_LAST    = 11;
    localparam int ST_OVERLEN = 5;
    localparam int ERR_W      = 5;
    localparam int LEN_W      = 16;
    localparam logic [31:0] ARM_VALUE = 32'h0100_0000;

    typedef enum logic [1:0] {
        ENG_WAIT,
        ENG_RECV,
        ENG_DROP
    } eng_state_e;
endpackage

// File: rtl/rx_bd_store.sv
// Descriptor memory: status, length and buffer address per descriptor.
// One host port (write and combinational read) and one engine port
// (combinational read of the current entry, write-back of status and
// length). The engine write-back wins over a same-cycle host write.
module rx_bd_store #(
    parameter int NUM_BD = 8,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic             host_word,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_data,
    input  logic [IDX_W-1:0] eng_idx,
    output logic [15:0]      eng_status,
    output logic [31:0]      eng_addr,
    input  logic             wb_we,
    input  logic [15:0]      wb_status,
    input  logic [15:0]      wb_len
);
    logic [15:0] st_q  [NUM_BD];
    logic [15:0] len_q [NUM_BD];
    logic [31:0] ptr_q [NUM_BD];

    // Hold descriptor words; host writes first, engine write-back last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BD; i++) begin
                st_q[i]  <= '0;
                len_q[i] <= '0;
                ptr_q[i] <= '0;
            end
        end else begin
            if (host_we && (int'(host_idx) < NUM_BD)) begin
                if (!host_word) begin
                    st_q[host_idx]  <= host_wdata[31:16];
                    len_q[host_idx] <= host_wdata[15:0];
                end else begin
                    ptr_q[host_idx] <= host_wdata;
                end
            end
            if (wb_we && (int'(eng_idx) < NUM_BD)) begin
                st_q[eng_idx]  <= wb_status;
                len_q[eng_idx] <= wb_len;
            end
        end
    end

    // Host read mux over the two words of a descriptor.
    always_comb begin
        host_data = '0;
        if (int'(host_idx) < NUM_BD)
            host_data = host_word ? ptr_q[host_idx] : {st_q[host_idx], len_q[host_idx]};
    end

    // Engine view of the current descriptor.
    always_comb begin
        eng_status = '0;
        eng_addr   = '0;
        if (int'(eng_idx) < NUM_BD) begin
            eng_status = st_q[eng_idx];
            eng_addr   = ptr_q[eng_idx];
        end
    end
endmodule

// File: rtl/rx_bd_regs.sv
// Control registers: enable, ring start index, arming poke and the
// sticky overrun counter. The poke is a single-cycle pulse decoded
// from an exact value; the counter saturates at its maximum.
module rx_bd_regs import rx_bd_pkg::*; #(
    parameter int IDX_W = 3,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       off,
    input  logic [31:0]      wdata,
    input  logic             ovr_inc,
    output logic             enable,
    output logic [IDX_W-1:0] start_idx,
    output logic             poke,
    output logic [CNT_W-1:0] ovr_cnt
);
    // Decode the arming write.
    assign poke = we && (off == 2'd2) && (wdata == ARM_VALUE);

    // Enable and ring start registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable    <= 1'b0;
            start_idx <= '0;
        end else if (we) begin
            if (off == 2'd0) enable <= wdata[0];
            if (off == 2'd1) start_idx <= wdata[IDX_W-1:0];
        end
    end

    // Saturating overrun counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_cnt <= '0;
        else if (ovr_inc && (ovr_cnt != '1))
            ovr_cnt <= ovr_cnt + 1'b1;
    end
endmodule

// File: rtl/rx_bd_fill.sv
// Frame fill engine. Takes the byte stream, stores bytes through the
// current descriptor's buffer pointer, writes back status and length on
// the last beat and advances the ring. Assumes the first beat of a frame
// is the first rx_valid beat after a beat with rx_last.
module rx_bd_fill import rx_bd_pkg::*; #(
    parameter int NUM_BD    = 8,
    parameter int IDX_W     = 3,
    parameter int BUF_MAX   = 1520,
    parameter int FRAME_MAX = 1518,
    parameter int ADDR_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic              poke,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic [ERR_W-1:0]  rx_err,
    input  logic [15:0]       cur_status,
    input  logic [31:0]       cur_addr,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              wb_we,
    output logic [15:0]       wb_status,
    output logic [15:0]       wb_len,
    output logic              ovr_inc,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_waddr,
    output logic [7:0]        buf_wdata
);
    localparam logic [LEN_W-1:0] BUF_LIM   = LEN_W'(BUF_MAX);
    localparam logic [LEN_W-1:0] FRAME_LIM = LEN_W'(FRAME_MAX);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_BD - 1);

    eng_state_e       state_q;
    logic [IDX_W-1:0] cur_q;
    logic             armed_q;
    logic [31:0]      base_q;
    logic [LEN_W-1:0] cnt_q;
    logic [ERR_W-1:0] err_q;

    logic             at_wait, desc_ready, take;
    logic [LEN_W-1:0] beat_off;
    logic [LEN_W:0]   total;
    logic [ERR_W-1:0] err_now;
    logic [31:0]      base_now;
    logic [IDX_W-1:0] next_idx;

    // Beat classification and frame bookkeeping values for this cycle.
    assign at_wait    = (state_q == ENG_WAIT);
    assign desc_ready = armed_q && cur_status[ST_EMPTY];
    assign take       = enable && rx_valid && ((state_q == ENG_RECV) || (at_wait && desc_ready));
    assign beat_off   = at_wait ? '0 : cnt_q;
    assign total      = {1'b0, beat_off} + 1'b1;
    assign err_now    = (at_wait ? '0 : err_q) | rx_err;
    assign base_now   = at_wait ? cur_addr : base_q;
    assign next_idx   = (cur_status[ST_WRAP] || (cur_q == LAST_IDX)) ? start_idx : cur_q + 1'b1;
    assign cur_idx    = cur_q;
    assign wb_we      = take && rx_last;
    assign ovr_inc    = enable && rx_valid && rx_last &&
                        ((state_q == ENG_DROP) || (at_wait && !desc_ready));
    assign wb_len     = (total > {1'b0, BUF_LIM}) ? BUF_LIM : total[LEN_W-1:0];

    // Closing status: hand back ownership, mark last, merge errors.
    always_comb begin
        wb_status              = cur_status;
        wb_status[ST_EMPTY]    = 1'b0;
        wb_status[ST_LAST]     = 1'b1;
        wb_status[5:0]         = '0;
        wb_status[ERR_W-1:0]   = err_now;
        wb_status[ST_OVERLEN]  = (total > {1'b0, FRAME_LIM});
    end

    // Frame state, ring pointer and arming.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state_q <= ENG_WAIT;
            cur_q   <= start_idx;
            armed_q <= 1'b0;
            base_q  <= '0;
            cnt_q   <= '0;
            err_q   <= '0;
        end else begin
            if (rx_valid) begin
                case (state_q)
                    ENG_WAIT: begin
                        base_q <= cur_addr;
                        cnt_q  <= 16'd1;
                        err_q  <= rx_err;
                        if (!rx_last) state_q <= desc_ready ? ENG_RECV : ENG_DROP;
                    end
                    ENG_RECV: begin
                        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
                        err_q <= err_now;
                        if (rx_last) state_q <= ENG_WAIT;
                    end
                    default: begin
                        if (rx_last) state_q <= ENG_WAIT;
                    end
                endcase
            end
            if (wb_we) cur_q <= next_idx;
            if (poke)
                armed_q <= 1'b1;
            else if (at_wait && !rx_valid && armed_q && !cur_status[ST_EMPTY])
                armed_q <= 1'b0;
            else if (at_wait && rx_valid && !desc_ready)
                armed_q <= 1'b0;
        end
    end

    // Registered byte write toward the buffer memory.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            buf_we    <= 1'b0;
            buf_waddr <= '0;
            buf_wdata <= '0;
        end else begin
            buf_we    <= take && (beat_off < BUF_LIM);
            buf_waddr <= ADDR_W'(base_now) + ADDR_W'(beat_off);
            buf_wdata <= rx_data;
        end
    end
endmodule

// File: rtl/rx_bd_ring.sv
// Top of the receive descriptor ring engine. Splits the host address
// space into descriptor words (top bit 0) and registers (top bit 1) and
// registers the read data. Assumes NUM_BD is a power of two.
module rx_bd_ring import rx_bd_pkg::*; #(
    parameter int NUM_BD    = 8,
    parameter int BUF_MAX   = 1520,
    parameter int FRAME_MAX = 1518,
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    localparam int IDX_W    = $clog2(NUM_BD),
    localparam int HA_W     = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [HA_W-1:0]   host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic [ERR_W-1:0]  rx_err,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_waddr,
    output logic [7:0]        buf_wdata
);
    logic             is_reg;
    logic             enable, poke, ovr_inc, wb_we;
    logic [IDX_W-1:0] start_idx, cur_idx;
    logic [CNT_W-1:0] ovr_cnt;
    logic [15:0]      cur_status, wb_status, wb_len;
    logic [31:0]      cur_addr, desc_rd;

    assign is_reg = host_addr[HA_W-1];

    rx_bd_store #(.NUM_BD(NUM_BD), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we && !is_reg), .host_idx(host_addr[HA_W-2:1]),
        .host_word(host_addr[0]), .host_wdata(host_wdata), .host_data(desc_rd),
        .eng_idx(cur_idx), .eng_status(cur_status), .eng_addr(cur_addr),
        .wb_we(wb_we), .wb_status(wb_status), .wb_len(wb_len)
    );

    rx_bd_regs #(.IDX_W(IDX_W), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .we(host_we && is_reg), .off(host_addr[1:0]), .wdata(host_wdata),
        .ovr_inc(ovr_inc), .enable(enable), .start_idx(start_idx),
        .poke(poke), .ovr_cnt(ovr_cnt)
    );

    rx_bd_fill #(.NUM_BD(NUM_BD), .IDX_W(IDX_W), .BUF_MAX(BUF_MAX),
                 .FRAME_MAX(FRAME_MAX), .ADDR_W(ADDR_W)) fill_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_idx(start_idx),
        .poke(poke), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_err(rx_err), .cur_status(cur_status), .cur_addr(cur_addr),
        .cur_idx(cur_idx), .wb_we(wb_we), .wb_status(wb_status), .wb_len(wb_len),
        .ovr_inc(ovr_inc), .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata)
    );

    // Registered host read from descriptor or register space.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= '0;
        else if (!is_reg)
            host_rdata <= desc_rd;
        else begin
            case (host_addr[1:0])
                2'd0:    host_rdata <= {31'b0, enable};
                2'd1:    host_rdata <= 32'(start_idx);
                2'd3:    host_rdata <= 32'(ovr_cnt);
                default: host_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/rx_bd_ring_chk.sv
// Property checker for the receive descriptor ring engine, bound to the top.
module rx_bd_ring_chk #(
    parameter int BUF_MAX = 1520,
    parameter int CNT_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             rx_valid,
    input logic             buf_we,
    input logic             wb_we,
    input logic [15:0]      wb_status,
    input logic [15:0]      wb_len,
    input logic [CNT_W-1:0] ovr_cnt
);
    // R2
    buf_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> $past(rx_valid));

    // R3
    owner_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |-> (!wb_status[15] && wb_status[11]));

    // R7
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |-> ((wb_len != 16'd0) && (wb_len <= 16'(BUF_MAX))));

    // R8
    ovr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_cnt == $past(ovr_cnt)) || (ovr_cnt == $past(ovr_cnt) + 1'b1));

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !enable) |=> !buf_we);
endmodule

bind rx_bd_ring rx_bd_ring_chk #(.BUF_MAX(BUF_MAX), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rx_valid(rx_valid),
    .buf_we(buf_we), .wb_we(wb_we), .wb_status(wb_status), .wb_len(wb_len),
    .ovr_cnt(ovr_cnt)
);

// File: tb/rx_bd_ring_tb_top.sv
`timescale 1ns/1ps
module rx_bd_ring_tb_top;
    localparam int NBD = 8;
    localparam int BUFM = 1520;
    localparam int FRM = 1518;
    localparam int HAW = 5;
    localparam int REG = 16;
    localparam logic [31:0] ARM = 32'h0100_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_we = 1'b0;
    logic [HAW-1:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0] rx_data = '0;
    logic [4:0] rx_err = '0;
    logic buf_we;
    logic [31:0] buf_waddr;
    logic [7:0] buf_wdata;

    int n_chk = 0, n_err = 0;
    int wr_seen = 0, wr_bad = 0, exp_limit = 0, pat_seed = 0;
    logic [31:0] exp_base = '0;

    always #2.5 clk = ~clk;

    rx_bd_ring #(.NUM_BD(NBD), .BUF_MAX(BUFM), .FRAME_MAX(FRM)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err), .buf_we(buf_we),
        .buf_waddr(buf_waddr), .buf_wdata(buf_wdata)
    );

    // Buffer write monitor against the generated byte pattern.
    always @(negedge clk) begin
        if (buf_we) begin
            if (wr_seen >= exp_limit || buf_waddr != exp_base + 32'(wr_seen) ||
                buf_wdata != 8'(pat_seed + wr_seen))
                wr_bad++;
            wr_seen++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input int a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = HAW'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hr(input int a, output logic [31:0] d);
        @(negedge clk);
        host_addr = HAW'(a);
        @(negedge clk);
        d = host_rdata;
    endtask

    function automatic logic [31:0] exp_w0(input int idx, input int len, input logic [4:0] err);
        logic [15:0] st;
        st = 16'h0800 | (idx == 3 ? 16'h2000 : 16'h0) | 16'(err) | (len > FRM ? 16'h0020 : 16'h0);
        return {st, 16'(len > BUFM ? BUFM : len)};
    endfunction

    task automatic send(input int len, input int seed, input logic [4:0] err, input int eb,
                        input logic [31:0] base, input int lim);
        wr_seen = 0; wr_bad = 0; exp_limit = lim; exp_base = base; pat_seed = seed;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'(seed + k); rx_last = (k == len - 1);
            rx_err = (k == eb) ? err : 5'h0;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = '0;
        repeat (2) @(negedge clk);
    endtask

    // Frame expected to land in descriptor idx (buffer 0x1000*(idx+1)).
    task automatic good_frame(input string req, input int idx, input int len,
                              input logic [4:0] err, input int eb);
        logic [31:0] w;
        int lim;
        lim = (len > BUFM) ? BUFM : len;
        send(len, idx * 7 + len, err, eb, 32'h1000 * (idx + 1), lim);
        chk({req, " byte count"}, 32'(wr_seen), 32'(lim));
        chk({req, " byte content"}, 32'(wr_bad), 0);
        hr(idx * 2, w);
        chk({req, " word0"}, w, exp_w0(idx, len, err));
    endtask

    task automatic recycle(input int idx);
        hw(idx * 2, {(idx == 3 ? 16'hA000 : 16'h8000), 16'h0});
        hw(REG + 2, ARM);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r, ovr0;
        int idx;
        void'($urandom(32'h5eed));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        hr(REG + 0, r); chk("R1 ctrl", r, 0);
        hr(REG + 3, r); chk("R1 overrun", r, 0);
        hr(0, r);       chk("R1 desc0", r, 0);
        chk("R1 no writes", 32'(wr_seen), 0);

        for (int i = 0; i < 4; i++) begin
            hw(i * 2 + 1, 32'h1000 * (i + 1));
            hw(i * 2, {(i == 3 ? 16'hA000 : 16'h8000), 16'h0});
        end
        // R10 read-back latency
        hr(3, r); chk("R10 desc1 ptr", r, 32'h2000);
        hw(REG + 1, 0); hw(REG + 0, 1); hw(REG + 2, ARM);
        hr(REG + 0, r); chk("R10 ctrl", r, 1);

        good_frame("R2 R3 basic", 0, 10, 5'h0, 0);
        good_frame("R6 errors", 1, 20, 5'h05, 7);
        good_frame("R3 single byte", 2, 1, 5'h0, 0);
        good_frame("R4 wrap desc", 3, 64, 5'h10, 63);

        // R8 ring back at desc0, still owned by software
        send(30, 3, 5'h0, 0, 0, 0);
        chk("R8 drop writes", 32'(wr_seen), 0);
        hr(REG + 3, r); chk("R8 overrun", r, 1);
        hr(0, r); chk("R8 desc unchanged", r, exp_w0(0, 10, 5'h0));
        // R5 empty again but no poke
        hw(0, {16'h8000, 16'h0});
        send(12, 4, 5'h0, 0, 0, 0);
        chk("R5 no poke writes", 32'(wr_seen), 0);
        hr(REG + 3, r); chk("R5 no poke overrun", r, 2);
        hw(REG + 2, 32'h0000_0001);
        send(12, 5, 5'h0, 0, 0, 0);
        hr(REG + 3, r); chk("R5 wrong poke overrun", r, 3);
        hw(REG + 2, ARM);
        good_frame("R4 R5 after wrap", 0, 16, 5'h0, 0);

        // Random frames with software recycling each descriptor
        idx = 1;
        for (int n = 0; n < 12; n++) begin
            int len, eb;
            logic [4:0] e;
            len = 1 + int'($urandom % 100);
            e = ($urandom % 4 == 0) ? 5'($urandom % 32) : 5'h0;
            eb = int'($urandom % len);
            recycle(idx);
            good_frame("R2 R4 R6 random", idx, len, e, eb);
            idx = (idx == 3) ? 0 : idx + 1;
        end

        // R7 length boundaries
        recycle(idx); good_frame("R7 at max", idx, FRM, 5'h0, 0);
        idx = (idx == 3) ? 0 : idx + 1;
        recycle(idx); good_frame("R7 one over", idx, FRM + 1, 5'h0, 0);
        idx = (idx == 3) ? 0 : idx + 1;
        recycle(idx); good_frame("R7 truncated", idx, BUFM + 10, 5'h0, 0);

        // R9 disable ignores input and returns to ring start
        hr(REG + 3, ovr0);
        hw(REG + 0, 0);
        send(12, 9, 5'h0, 0, 0, 0);
        chk("R9 disabled writes", 32'(wr_seen), 0);
        hr(REG + 3, r); chk("R9 disabled overrun", r, ovr0);
        hw(REG + 1, 2);
        hr(REG + 1, r); chk("R9 start reg", r, 2);
        hw(REG + 0, 1);
        recycle(2); good_frame("R9 restart at start", 2, 40, 5'h0, 0);
        recycle(3); good_frame("R9 wrap desc", 3, 8, 5'h0, 0);
        recycle(2); good_frame("R4 wrap to start 2", 2, 9, 5'h0, 0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule